// File: doc/BRIEF.md
# Four-Level Return Stack with Saved Carry

This block holds return addresses for a small processor core. Each subroutine call or interrupt entry pushes the 12-bit program counter together with the current carry flag as one 13-bit word. Each return pops the most recent word. There are four levels, and calls and interrupts share them. When a fifth word is pushed onto a full stack, the oldest word falls off the bottom and is lost.

There are two kinds of return. An interrupt return hands the saved carry back to the core and raises a carry-load enable. A return-constant hands back only the address and leaves the core's carry alone. The block also flags a push that loses an entry and a pop from an empty stack. A pop from an empty stack returns all zeros.

Top module: `ret_stack`

## Requirements
- R1: A popped entry carries the PC and carry of the most recent unpopped push, so entries come back in last-in, first-out order. The word layout is carry in bit 12 and PC in bits 11..0.
- R2: `depth_o` counts the stored entries from 0 to 4. It rises by one on a push alone and falls by one on a pop alone from a non-empty stack.
- R3: A push alone onto a full stack discards the oldest entry and keeps the depth at 4. `overflow_o` is high in that same cycle.
- R4: A pop from an empty stack drives `underflow_o` high in that cycle, returns zero on `ret_pc_o` and `ret_cy_o`, keeps `cy_load_o` low and leaves the depth unchanged.
- R5: A pop with `pop_irq_i`=1 (interrupt return) from a non-empty stack raises `cy_load_o` and presents the stored carry on `ret_cy_o`.
- R6: A pop with `pop_irq_i`=0 (return-constant) keeps `cy_load_o` low, so the stored carry is not applied.
- R7: When `push_i` and `pop_i` are both high in one cycle, the pop returns the current top entry and the pushed word replaces it. The depth stays unchanged, or becomes 1 if the stack was empty.
- R8: While `rst_n` is low at a clock edge, the stack is cleared to empty. After reset, `depth_o` is 0 and no flag is raised.
- R9: In a cycle with no pop, `ret_pc_o`, `ret_cy_o` and `cy_load_o` are all zero. All return outputs and flags are combinational in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Push request (call or interrupt entry) |
| push_pc_i | input | 12 | PC to save |
| push_cy_i | input | 1 | Carry flag to save |
| pop_i | input | 1 | Pop request (any return) |
| pop_irq_i | input | 1 | 1 = interrupt return, 0 = return-constant |
| ret_pc_o | output | 12 | Popped PC |
| ret_cy_o | output | 1 | Popped carry |
| cy_load_o | output | 1 | Core should load `ret_cy_o` into its carry |
| overflow_o | output | 1 | An oldest entry is being lost |
| underflow_o | output | 1 | Pop of an empty stack |
| depth_o | output | 3 | Number of stored entries |

## Verification
A push and a pop can fall in the same cycle, for example when an interrupt arrives just as a return executes. The random stimulus raises both requests together often, at every depth from empty to full. Directed steps cover the two extremes. In each such cycle, the bench checks that the returned word is the top entry from before the edge. On the following cycles it checks that the new word sits on top, that the depth is unchanged (or 1 if the stack started empty), and that no flag fires falsely.

// File: rtl/ret_stack_pkg.sv
// Package: shared types for the return stack.
// Assumes: one operation per cycle is chosen by the control logic.
package ret_stack_pkg;
    typedef enum logic [1:0] {
        SOP_HOLD  = 2'd0,  // keep contents
        SOP_DOWN  = 2'd1,  // push: everything moves one level deeper
        SOP_UP    = 2'd2,  // pop: everything moves one level up
        SOP_SWAP  = 2'd3   // push and pop together: top replaced
    } slot_op_e;
endpackage

// File: rtl/ret_stack_slot.sv
// Module: one storage level of the return stack.
// Loads from the level above on a push, from the level below on a pop,
// and (top level only) from the level above on a swap.
// Assumes: the parent feeds the new word as "above" for the top level
// and zero as "below" for the bottom level.
module ret_stack_slot
    import ret_stack_pkg::*;
#(
    parameter int W      = 13,
    parameter bit IS_TOP = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  slot_op_e     op_i,
    input  logic [W-1:0] above_i,
    input  logic [W-1:0] below_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_q;

    // Storage register: select source per operation, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            case (op_i)
                SOP_DOWN: q_q <= above_i;
                SOP_UP:   q_q <= below_i;
                SOP_SWAP: if (IS_TOP) q_q <= above_i;
                default:  q_q <= q_q;
            endcase
        end
    end

    assign q_o = q_q;
endmodule

// File: rtl/ret_stack_ctrl.sv
// Module: occupancy counter and operation decode for the return stack.
// Decides the storage operation, tracks depth, raises overflow/underflow.
// Assumes: push and pop may be requested in the same cycle.
module ret_stack_ctrl
    import ret_stack_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output slot_op_e         op_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             empty_o,
    output logic             overflow_o,
    output logic             underflow_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             full;

    assign full    = (cnt_q == FULL_CNT);
    assign empty_o = (cnt_q == '0);

    // Operation decode: which way the storage levels move this cycle.
    always_comb begin
        if (push_i && pop_i)      op_o = SOP_SWAP;
        else if (push_i)          op_o = SOP_DOWN;
        else if (pop_i && !empty_o) op_o = SOP_UP;
        else                      op_o = SOP_HOLD;
    end

    // Next depth: saturate at full, floor at empty, swap keeps level.
    always_comb begin
        cnt_d = cnt_q;
        if (push_i && pop_i)  cnt_d = empty_o ? ONE_CNT : cnt_q;
        else if (push_i)      cnt_d = full ? cnt_q : cnt_q + ONE_CNT;
        else if (pop_i)       cnt_d = empty_o ? cnt_q : cnt_q - ONE_CNT;
    end

    // Depth register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign overflow_o  = push_i && !pop_i && full;
    assign underflow_o = pop_i && empty_o;
    assign cnt_o       = cnt_q;

    // R2: depth never exceeds the number of levels.
    a_r2_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);
    // R2: a lone push below full adds one level.
    a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full) |=> (cnt_q == $past(cnt_q) + ONE_CNT));
    // R3: losing an entry leaves the stack full.
    a_r3_overflow_full: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> (cnt_q == FULL_CNT));
    // R4: a lone pop of an empty stack keeps it empty.
    a_r4_underflow_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_o && !push_i) |=> (cnt_q == '0));
    // R7: simultaneous push and pop on a non-empty stack keeps depth.
    a_r7_swap_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !empty_o) |=> $stable(cnt_q));
endmodule

// File: rtl/ret_stack_port.sv
// Module: return-side formatting for the return stack.
// Splits the top word into PC and carry, zeroes it when no valid pop,
// and raises the carry-load enable only for interrupt returns.
// Assumes: top_i is the current top entry, carry in the MSB.
module ret_stack_port #(
    parameter int PC_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pop_i,
    input  logic            irq_i,
    input  logic            empty_i,
    input  logic [PC_W:0]   top_i,
    output logic [PC_W-1:0] ret_pc_o,
    output logic            ret_cy_o,
    output logic            cy_load_o
);
    logic hit;

    // Return word: top entry on a valid pop, zero otherwise.
    always_comb begin
        hit       = pop_i && !empty_i;
        ret_pc_o  = hit ? top_i[PC_W-1:0] : '0;
        ret_cy_o  = hit ? top_i[PC_W] : 1'b0;
        cy_load_o = hit && irq_i;
    end

    // R4: an empty pop returns zero and never loads the carry.
    a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_i) |-> (ret_pc_o == '0 && !ret_cy_o && !cy_load_o));
    // R6: return-constant never loads the carry.
    a_r6_const_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !irq_i) |-> !cy_load_o);
    // R9: no pop, no return data.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_i |-> (ret_pc_o == '0 && !ret_cy_o && !cy_load_o));
endmodule

// File: rtl/ret_stack.sv
// Module: four-level return stack saving carry and PC.
// Level 0 is the top; pushes shift older words deeper, the deepest is
// dropped when full; pops shift words up and fill the bottom with zero.
// Assumes: one push and/or one pop request per cycle.
module ret_stack
    import ret_stack_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [PC_W-1:0]              push_pc_i,
    input  logic                         push_cy_i,
    input  logic                         pop_i,
    input  logic                         pop_irq_i,
    output logic [PC_W-1:0]              ret_pc_o,
    output logic                         ret_cy_o,
    output logic                         cy_load_o,
    output logic                         overflow_o,
    output logic                         underflow_o,
    output logic [$clog2(DEPTH+1)-1:0]   depth_o
);
    localparam int W     = PC_W + 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    slot_op_e     op;
    logic         empty;
    logic [W-1:0] new_word;
    logic [W-1:0] lvl [DEPTH];

    assign new_word = {push_cy_i, push_pc_i};

    ret_stack_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .op_o        (op),
        .cnt_o       (depth_o),
        .empty_o     (empty),
        .overflow_o  (overflow_o),
        .underflow_o (underflow_o)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
        logic [W-1:0] above, below;
        if (i == 0) begin : g_top
            assign above = new_word;
        end else begin : g_mid
            assign above = lvl[i-1];
        end
        if (i == DEPTH - 1) begin : g_bot
            assign below = '0;
        end else begin : g_upper
            assign below = lvl[i+1];
        end
        ret_stack_slot #(.W(W), .IS_TOP(i == 0)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .op_i    (op),
            .above_i (above),
            .below_i (below),
            .q_o     (lvl[i])
        );
    end

    ret_stack_port #(.PC_W(PC_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_i     (pop_i),
        .irq_i     (pop_irq_i),
        .empty_i   (empty),
        .top_i     (lvl[0]),
        .ret_pc_o  (ret_pc_o),
        .ret_cy_o  (ret_cy_o),
        .cy_load_o (cy_load_o)
    );

    // R1: any push leaves the pushed word on top.
    a_r1_push_on_top: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (lvl[0] == $past(new_word)));
endmodule

// File: tb/ret_stack_bench.sv
// Bench: random and directed push/pop traffic against a bench model.
module ret_stack_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_i, push_cy_i, pop_i, pop_irq_i;
    logic [11:0] push_pc_i;
    logic [11:0] ret_pc_o;
    logic        ret_cy_o, cy_load_o, overflow_o, underflow_o;
    logic [2:0]  depth_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [12:0] m_stk [4];
    int          m_n;

    always #5 clk = ~clk;

    ret_stack u_ret_stack (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_i), .push_pc_i(push_pc_i), .push_cy_i(push_cy_i),
        .pop_i(pop_i), .pop_irq_i(pop_irq_i),
        .ret_pc_o(ret_pc_o), .ret_cy_o(ret_cy_o), .cy_load_o(cy_load_o),
        .overflow_o(overflow_o), .underflow_o(underflow_o), .depth_o(depth_o)
    );

    function automatic logic [12:0] exp_ret(input logic pop);
        return (pop && m_n > 0) ? m_stk[0] : 13'd0;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Apply one cycle: drive after posedge, check mid-cycle, update model.
    task automatic step(input logic ps, input logic [11:0] pc, input logic cy,
                        input logic pp, input logic irq);
        logic [12:0] er;
        @(posedge clk); #1;
        push_i = ps; push_pc_i = pc; push_cy_i = cy; pop_i = pp; pop_irq_i = irq;
        #3;
        er = exp_ret(pp);
        chk(pp ? "R1" : "R9", "ret_pc", int'(ret_pc_o), int'(er[11:0]));
        chk(pp && irq ? "R5" : "R9", "ret_cy", int'(ret_cy_o), int'(er[12]));
        chk(pp && !irq ? "R6" : "R5", "cy_load", int'(cy_load_o),
            int'(pp && irq && m_n > 0));
        chk("R3", "overflow", int'(overflow_o), int'(ps && !pp && m_n == 4));
        chk("R4", "underflow", int'(underflow_o), int'(pp && m_n == 0));
        chk(ps && pp ? "R7" : "R2", "depth", int'(depth_o), m_n);
        // model update
        if (ps && pp) begin
            m_stk[0] = {cy, pc};
            if (m_n == 0) m_n = 1;
        end else if (ps) begin
            for (int i = 3; i > 0; i--) m_stk[i] = m_stk[i-1];
            m_stk[0] = {cy, pc};
            if (m_n < 4) m_n++;
        end else if (pp && m_n > 0) begin
            for (int i = 0; i < 3; i++) m_stk[i] = m_stk[i+1];
            m_stk[3] = 13'd0;
            m_n--;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd6611));
        rst_n = 1'b0; push_i = 0; push_pc_i = 0; push_cy_i = 0; pop_i = 0; pop_irq_i = 0;
        for (int i = 0; i < 4; i++) m_stk[i] = 13'd0;
        m_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #3;
        chk("R8", "depth after reset", int'(depth_o), 0);
        chk("R8", "flags after reset", int'({overflow_o, underflow_o, cy_load_o}), 0);
        // R4: pop on empty, both kinds
        step(0, 12'h000, 0, 1, 1);
        step(0, 12'h000, 0, 1, 0);
        // R3: five pushes, oldest lost; then pop all with mixed kinds
        for (int i = 0; i < 5; i++) step(1, 12'h100 + 12'(i), 1'(i), 0, 0);
        for (int i = 0; i < 5; i++) step(0, 12'h000, 0, 1, 1'(i));
        // R7: swap on empty and on full
        step(1, 12'hABC, 1, 1, 1);
        for (int i = 0; i < 3; i++) step(1, 12'h200 + 12'(i), 0, 0, 0);
        step(1, 12'h3FF, 1, 1, 0);
        step(0, 12'h000, 0, 1, 1);
        // R8: mid-run reset clears the stack
        @(posedge clk); #1 rst_n = 1'b0; push_i = 0; pop_i = 0;
        @(posedge clk); #1 rst_n = 1'b1;
        for (int i = 0; i < 4; i++) m_stk[i] = 13'd0;
        m_n = 0;
        #3 chk("R8", "depth after mid reset", int'(depth_o), 0);
        // random traffic
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = int'($urandom_range(0, 99));
            step(r < 55, 12'($urandom()), 1'($urandom()), (r >= 30 && r < 85) || r >= 95,
                 1'($urandom()));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule